// File: doc/BRIEF.md
# Group-Quantized Dot-Product Unit

This block forms the dot product of one group of low-bit unsigned weight codes with half-precision (FP16) activations and returns a dequantized partial result. A group holds `GROUP` activation/weight pairs. They arrive on a valid/ready stream, `LANES` pairs per beat. One FP16 scale, one small unsigned zero point and a weight-width select come with the first beat of each group.

The unit works in two passes over a buffered copy of the group. While the beats arrive, it stores them and tracks the largest activation exponent. It then replays the buffer. In the replay, each activation mantissa is shifted to that shared exponent and truncated, multiplied by its zero-extended weight code, and accumulated. The sum of the aligned activations is accumulated alongside. Finally the zero point is removed in one step by subtracting the activation sum times the zero point, and the result is multiplied by the scale's signed mantissa. The output is a signed integer mantissa and a signed power-of-two exponent, and the value is `out_mant * 2^out_exp`. Rounding to a float format and combining several groups are left to the surrounding datapath.

Top module: `gq_dot_unit`

## Requirements
- R1: `in_ready` is high in the load phase and a beat is taken on each cycle where `in_valid` and `in_ready` are both high, including beats separated by idle cycles. From the cycle after the `GROUP/LANES`-th beat until `out_valid`, `in_ready` is low. Element `b*LANES+l` of a group travels in beat `b`, lane `l`: activation bits `[l*16 +: 16]` and weight bits `[l*4 +: 4]`.
- R2: `in_scale`, `in_zp` and `in_wide` are sampled only on the first beat of a group. Their values on later beats have no effect on the result.
- R3: The shared exponent `E` is the largest effective exponent in the group. An activation with exponent field 0 (zero or subnormal) counts as exponent 1 and has no hidden bit.
- R4: Each activation magnitude (hidden bit plus 10 fraction bits) is shifted right by `E` minus its own effective exponent, with the low bits dropped, and then takes the activation's sign. So `out_mant*2^out_exp` differs from the exact real result by at most `sum|w-zp| * 2^(E-25) * |scale|`.
- R5: Weight codes are unsigned and zero-extended. With `in_wide`=1 a code is the 4 lane bits (0..15). With `in_wide`=0 it is the low 2 lane bits (0..3), and the upper 2 bits are ignored.
- R6: `out_mant = (D - V*zp) * S`. Here `D` is the sum of aligned activation times weight code, `V` is the sum of aligned activations, and `S` is the scale's hidden bit plus fraction, negated when the scale's sign bit is set.
- R7: `out_exp = E + Es - 50`, where `Es` is the scale's effective exponent (field 0 counts as 1). This folds two FP16 biases of 15 and two 10-bit fraction scalings into one term.
- R8: `out_valid` is a single-cycle pulse raised `GROUP/LANES + 2` cycles after the clock edge that takes the last beat, with `out_mant` and `out_exp` valid in that cycle.
- R9: `err` becomes 1 when an accepted activation, or the scale of a group, has exponent field 31 (infinity or NaN). After that it stays 1 until reset.
- R10: After reset, `out_valid`=0, `err`=0, `in_ready`=1 and `out_mant`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be taken |
| in_act | input | LANES*16 | FP16 activations, lane l at [l*16 +: 16] |
| in_wgt | input | LANES*4 | Unsigned weight codes, lane l at [l*4 +: 4] |
| in_scale | input | 16 | Group FP16 scale (sampled on first beat) |
| in_zp | input | 2 | Group zero point (sampled on first beat) |
| in_wide | input | 1 | 1: 4-bit codes, 0: 2-bit codes (sampled on first beat) |
| out_valid | output | 1 | Result pulse |
| out_mant | output | 36 | Signed result mantissa |
| out_exp | output | 8 | Signed result exponent |
| err | output | 1 | Sticky unsupported-input flag |

## Verification
The checker watches the protocol on every cycle. It confirms that `in_ready` stays low between a group's last beat and its result, that the result pulse lasts one cycle and lands exactly `GROUP/LANES + 2` cycles after the last beat, that the output exponent stays in its legal range, and that the error flag never clears. Only the bench scenarios can show the arithmetic. These are the exact mantissa and exponent under every zero point, both weight widths and both scale signs. They also cover truncation when exponents are widely spread, subnormal and all-zero groups, metadata changes after the first beat being ignored, and agreement with a real-valued reference inside the truncation bound.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int FP_W      = 16;
  localparam int FP_EXP_W  = 5;
  localparam int FP_FRAC_W = 10;
  localparam int FP_BIAS   = 15;
  localparam int FP_MANT_W = FP_FRAC_W + 1;

  typedef enum logic [1:0] {ST_LOAD, ST_ALIGN, ST_CORR, ST_SCALE} gq_state_e;

  // Exponent used for alignment: zero/subnormal behave as exponent 1.
  function automatic logic [FP_EXP_W-1:0] eff_exp(input logic [FP_EXP_W-1:0] e);
    return (e == '0) ? FP_EXP_W'(1) : e;
  endfunction

  // Unsigned magnitude with hidden bit (absent for zero/subnormal).
  function automatic logic [FP_MANT_W-1:0] fp_mag(input logic [FP_W-1:0] v);
    return {(v[FP_W-2 -: FP_EXP_W] != '0), v[FP_FRAC_W-1:0]};
  endfunction
endpackage

// File: rtl/gq_exp_max.sv
module gq_exp_max
  import gq_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [LANES*FP_EXP_W-1:0] exps,
  output logic [FP_EXP_W-1:0]       beat_max,
  output logic                      any_special
);
  always_comb begin
    beat_max    = FP_EXP_W'(1);
    any_special = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (eff_exp(exps[l*FP_EXP_W +: FP_EXP_W]) > beat_max)
        beat_max = eff_exp(exps[l*FP_EXP_W +: FP_EXP_W]);
      if (exps[l*FP_EXP_W +: FP_EXP_W] == '1)
        any_special = 1'b1;
    end
  end
endmodule

// File: rtl/gq_lane_mac.sv
module gq_lane_mac
  import gq_pkg::*;
#(
  parameter int WGT_W    = 4,
  parameter int NARROW_W = 2,
  parameter int AL_W     = FP_MANT_W + 1,
  parameter int PROD_W   = AL_W + WGT_W + 1
) (
  input  logic [FP_W-1:0]         act,
  input  logic [WGT_W-1:0]        wgt,
  input  logic                    wide,
  input  logic [FP_EXP_W-1:0]     max_exp,
  output logic signed [AL_W-1:0]  aligned,
  output logic signed [PROD_W-1:0] prod
);
  logic [FP_EXP_W-1:0]  shamt;
  logic [FP_MANT_W-1:0] mag_sh;
  logic [WGT_W-1:0]     wz;

  always_comb begin
    shamt   = max_exp - eff_exp(act[FP_W-2 -: FP_EXP_W]);
    mag_sh  = fp_mag(act) >> shamt;
    aligned = act[FP_W-1] ? -$signed({1'b0, mag_sh}) : $signed({1'b0, mag_sh});
    wz      = wide ? wgt : {{(WGT_W-NARROW_W){1'b0}}, wgt[NARROW_W-1:0]};
    prod    = PROD_W'(aligned) * PROD_W'($signed({1'b0, wz}));
  end
endmodule

// File: rtl/gq_dot_unit.sv
module gq_dot_unit
  import gq_pkg::*;
#(
  parameter int GROUP    = 128,
  parameter int LANES    = 16,
  parameter int WGT_W    = 4,
  parameter int NARROW_W = 2,
  parameter int ZP_W     = 2,
  parameter int EXP_O_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*FP_W-1:0]         in_act,
  input  logic [LANES*WGT_W-1:0]        in_wgt,
  input  logic [FP_W-1:0]               in_scale,
  input  logic [ZP_W-1:0]               in_zp,
  input  logic                          in_wide,
  output logic                          out_valid,
  output logic signed [FP_MANT_W+FP_MANT_W+WGT_W+$clog2(GROUP)+2:0] out_mant,
  output logic signed [EXP_O_W-1:0]     out_exp,
  output logic                          err
);
  localparam int BEATS  = GROUP / LANES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int AL_W   = FP_MANT_W + 1;
  localparam int PROD_W = AL_W + WGT_W + 1;
  localparam int ACC_W  = AL_W + WGT_W + $clog2(GROUP);
  localparam int VS_W   = AL_W + $clog2(GROUP);
  localparam int COR_W  = ACC_W + 1;
  localparam int OUT_W  = COR_W + FP_MANT_W + 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  gq_state_e state_q;
  logic [BEAT_W-1:0]       idx_q;
  logic [FP_EXP_W-1:0]     maxe_q;
  logic [FP_W-1:0]         scale_q;
  logic [ZP_W-1:0]         zp_q;
  logic                    wide_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [VS_W-1:0]  vs_q;
  logic signed [COR_W-1:0] corr_q;

  logic [LANES*FP_W-1:0]  act_mem [BEATS];
  logic [LANES*WGT_W-1:0] wgt_mem [BEATS];
  logic [LANES*FP_W-1:0]  rd_act;
  logic [LANES*WGT_W-1:0] rd_wgt;

  logic accept;
  assign in_ready = (state_q == ST_LOAD);
  assign accept   = in_valid & in_ready;

  // Pass one: exponent scan of the incoming beat.
  logic [LANES*FP_EXP_W-1:0] in_exps;
  logic [FP_EXP_W-1:0]       beat_max;
  logic                      beat_special;
  always_comb
    for (int l = 0; l < LANES; l++)
      in_exps[l*FP_EXP_W +: FP_EXP_W] = in_act[l*FP_W + FP_W-2 -: FP_EXP_W];

  gq_exp_max #(.LANES(LANES)) u_exp_max (
    .exps(in_exps), .beat_max(beat_max), .any_special(beat_special)
  );

  // Group buffer, one word per beat.
  always_ff @(posedge clk) begin
    if (accept) begin
      act_mem[idx_q] <= in_act;
      wgt_mem[idx_q] <= in_wgt;
    end
  end
  assign rd_act = act_mem[idx_q];
  assign rd_wgt = wgt_mem[idx_q];

  // Pass two: per-lane alignment and product.
  logic signed [AL_W-1:0]   lane_al   [LANES];
  logic signed [PROD_W-1:0] lane_prod [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gq_lane_mac #(.WGT_W(WGT_W), .NARROW_W(NARROW_W), .AL_W(AL_W), .PROD_W(PROD_W)) u_mac (
      .act(rd_act[g*FP_W +: FP_W]), .wgt(rd_wgt[g*WGT_W +: WGT_W]),
      .wide(wide_q), .max_exp(maxe_q), .aligned(lane_al[g]), .prod(lane_prod[g])
    );
  end

  logic signed [ACC_W-1:0] beat_dot;
  logic signed [VS_W-1:0]  beat_vs;
  always_comb begin
    beat_dot = '0;
    beat_vs  = '0;
    for (int l = 0; l < LANES; l++) begin
      beat_dot = beat_dot + ACC_W'(lane_prod[l]);
      beat_vs  = beat_vs + VS_W'(lane_al[l]);
    end
  end

  // Final stages: zero-point removal, then scale.
  logic signed [COR_W-1:0]   acc_x, vs_x, zp_x;
  logic signed [OUT_W-1:0]   cor_x, sm_x;
  logic signed [AL_W-1:0]    scale_sm;
  logic [EXP_O_W-1:0]        exp_sum;
  always_comb begin
    acc_x    = COR_W'(acc_q);
    vs_x     = COR_W'(vs_q);
    zp_x     = COR_W'($signed({1'b0, zp_q}));
    scale_sm = scale_q[FP_W-1] ? -$signed({1'b0, fp_mag(scale_q)})
                               :  $signed({1'b0, fp_mag(scale_q)});
    cor_x    = OUT_W'(corr_q);
    sm_x     = OUT_W'(scale_sm);
    exp_sum  = EXP_O_W'(maxe_q) + EXP_O_W'(eff_exp(scale_q[FP_W-2 -: FP_EXP_W]))
             - EXP_O_W'(2 * (FP_BIAS + FP_FRAC_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_LOAD;
      idx_q     <= '0;
      maxe_q    <= FP_EXP_W'(1);
      scale_q   <= '0;
      zp_q      <= '0;
      wide_q    <= 1'b0;
      acc_q     <= '0;
      vs_q      <= '0;
      corr_q    <= '0;
      out_valid <= 1'b0;
      out_mant  <= '0;
      out_exp   <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        ST_LOAD: if (accept) begin
          if (idx_q == '0) begin
            scale_q <= in_scale;
            zp_q    <= in_zp;
            wide_q  <= in_wide;
            maxe_q  <= beat_max;
            err     <= err | beat_special | (in_scale[FP_W-2 -: FP_EXP_W] == '1);
          end else begin
            if (beat_max > maxe_q) maxe_q <= beat_max;
            err <= err | beat_special;
          end
          if (idx_q == LAST) begin
            idx_q   <= '0;
            acc_q   <= '0;
            vs_q    <= '0;
            state_q <= ST_ALIGN;
          end else begin
            idx_q <= idx_q + BEAT_W'(1);
          end
        end
        ST_ALIGN: begin
          acc_q <= acc_q + beat_dot;
          vs_q  <= vs_q + beat_vs;
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_CORR;
          end else begin
            idx_q <= idx_q + BEAT_W'(1);
          end
        end
        ST_CORR: begin
          corr_q  <= acc_x - vs_x * zp_x;
          state_q <= ST_SCALE;
        end
        default: begin
          out_mant  <= cor_x * sm_x;
          out_exp   <= $signed(exp_sum);
          out_valid <= 1'b1;
          state_q   <= ST_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/gq_dot_unit_chk.sv
module gq_dot_unit_chk #(
  parameter int GROUP   = 128,
  parameter int LANES   = 16,
  parameter int EXP_O_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      err,
  input logic signed [EXP_O_W-1:0] out_exp
);
  localparam int BEATS  = GROUP / LANES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int GAP_W  = $clog2(BEATS + 4) + 1;

  logic [BEAT_W-1:0] cnt_q;
  logic [GAP_W-1:0]  since_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      since_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        if (cnt_q == BEAT_W'(BEATS - 1)) begin
          cnt_q   <= '0;
          armed_q <= 1'b1;
          since_q <= '0;
        end else begin
          cnt_q <= cnt_q + BEAT_W'(1);
        end
      end else if (armed_q) begin
        if (out_valid) armed_q <= 1'b0;
        since_q <= since_q + GAP_W'(1);
      end
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !out_valid) |-> !in_ready);
  p_ready_at_out_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (armed_q && since_q == GAP_W'(BEATS + 2)));
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_exp_range_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_exp >= -48 && out_exp <= 10));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind gq_dot_unit gq_dot_unit_chk #(.GROUP(GROUP), .LANES(LANES), .EXP_O_W(EXP_O_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .err(err), .out_exp(out_exp)
);

// File: tb/gq_dot_unit_bench.sv
module gq_dot_unit_bench;
  localparam int GROUP = 128;
  localparam int LANES = 16;
  localparam int BEATS = GROUP / LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*16-1:0] in_act = '0;
  logic [LANES*4-1:0]  in_wgt = '0;
  logic [15:0] in_scale = '0;
  logic [1:0]  in_zp = '0;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic signed [35:0] out_mant;
  logic signed [7:0]  out_exp;
  logic        err;

  always #2 clk = ~clk;

  gq_dot_unit u_gq_dot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_act(in_act), .in_wgt(in_wgt), .in_scale(in_scale), .in_zp(in_zp),
    .in_wide(in_wide), .out_valid(out_valid), .out_mant(out_mant),
    .out_exp(out_exp), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] g_act [GROUP];
  logic [3:0]  g_wgt [GROUP];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real p2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic int effe(input logic [4:0] e);
    return (e == 0) ? 1 : int'(e);
  endfunction

  function automatic longint magof(input logic [15:0] v);
    return (v[14:10] == 0) ? longint'(v[9:0]) : longint'(v[9:0]) + 1024;
  endfunction

  function automatic logic [15:0] mk(input int sgn, input int e, input int frac);
    return {sgn[0], e[4:0], frac[9:0]};
  endfunction

  task automatic run_group(input bit wide, input logic [1:0] zp, input logic [15:0] sc,
                           input bit noise, input bit gaps, input bit check_math);
    int maxe = 1;
    longint dotv = 0, vs = 0, a, w, sm, emant;
    int eexp, lat;
    real ideal = 0.0, bnd = 0.0, scr, dut;
    for (int i = 0; i < GROUP; i++)
      if (effe(g_act[i][14:10]) > maxe) maxe = effe(g_act[i][14:10]);
    for (int i = 0; i < GROUP; i++) begin
      a = magof(g_act[i]) >>> (maxe - effe(g_act[i][14:10]));
      if (g_act[i][15]) a = -a;
      w = wide ? longint'(g_wgt[i]) : longint'(g_wgt[i][1:0]);
      dotv += a * w;
      vs   += a;
      ideal += (g_act[i][15] ? -1.0 : 1.0) * real'(magof(g_act[i])) *
               p2(effe(g_act[i][14:10]) - 25) * real'(w - longint'(zp));
      bnd   += ((w >= zp) ? real'(w - zp) : real'(zp - w)) * p2(maxe - 25);
    end
    sm = magof(sc);
    if (sc[15]) sm = -sm;
    emant = (dotv - vs * longint'(zp)) * sm;
    eexp  = maxe + effe(sc[14:10]) - 50;
    scr   = real'(sm) * p2(effe(sc[14:10]) - 25);
    ideal = ideal * scr;
    bnd   = bnd * ((scr < 0.0) ? -scr : scr) + 1.0e-30;

    for (int b = 0; b < BEATS; b++) begin
      if (gaps && (b == 3 || b == 6)) begin
        in_valid = 1'b0;
        in_scale = ~sc;
        @(negedge clk);
      end
      in_valid = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        in_act[l*16 +: 16] = g_act[b*LANES + l];
        in_wgt[l*4 +: 4]   = g_wgt[b*LANES + l];
      end
      in_scale = (b == 0 || !noise) ? sc : (sc ^ 16'h8000);
      in_zp    = (b == 0 || !noise) ? zp : (zp ^ 2'b01);
      in_wide  = (b == 0 || !noise) ? wide : ~wide;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1 ready low after last beat", longint'(in_ready), 0);
    lat = 0;
    for (int k = 1; k <= BEATS + 6; k++) begin
      @(negedge clk);
      if (out_valid) begin lat = k; break; end
    end
    check(lat == BEATS + 2, "R8 result latency", lat, BEATS + 2);
    if (check_math) begin
      check(out_mant == emant, "R6 mantissa", longint'(out_mant), emant);
      check(int'(out_exp) == eexp, "R7 exponent", int'(out_exp), eexp);
      dut = real'(longint'(out_mant)) * p2(int'(out_exp));
      check((dut - ideal <= bnd) && (ideal - dut <= bnd), "R4 truncation bound",
            longint'(dut * 1.0e6), longint'(ideal * 1.0e6));
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R8 single-cycle pulse", longint'(out_valid), 0);
  endtask

  task automatic fill_random(input int elo, input int ehi);
    for (int i = 0; i < GROUP; i++) begin
      g_act[i] = mk($urandom_range(1, 0), $urandom_range(ehi, elo), $urandom_range(1023, 0));
      g_wgt[i] = 4'($urandom_range(15, 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", longint'(out_valid), 0);
    check(err == 1'b0, "R10 err after reset", longint'(err), 0);
    check(in_ready == 1'b1, "R10 ready after reset", longint'(in_ready), 1);
    check(out_mant == 0, "R10 mant after reset", longint'(out_mant), 0);

    // Sweep: every zero point, both widths (R5), both scale signs (R6).
    for (int zp = 0; zp < 4; zp++)
      for (int wd = 0; wd < 2; wd++)
        for (int ss = 0; ss < 2; ss++) begin
          fill_random(8, 20);
          run_group(wd[0], 2'(zp), mk(ss, $urandom_range(18, 10), $urandom_range(1023, 0)), 0, 0, 1);
        end

    // R3: zero and subnormal activations, subnormal scale.
    for (int i = 0; i < GROUP; i++) begin
      g_act[i] = (i % 3 == 0) ? 16'h0000 : mk(i % 2, 0, $urandom_range(1023, 0));
      g_wgt[i] = 4'($urandom_range(15, 0));
    end
    run_group(1, 2'd2, mk(0, 0, 700), 0, 0, 1);

    // R4: wide exponent spread, most lanes truncate to zero.
    fill_random(1, 6);
    g_act[77] = mk(1, 30, 1023);
    run_group(1, 2'd1, mk(0, 15, 0), 0, 0, 1);

    // R5: maximum codes, high bits set in narrow mode.
    fill_random(14, 16);
    for (int i = 0; i < GROUP; i++) g_wgt[i] = 4'hF;
    run_group(0, 2'd0, mk(0, 15, 0), 0, 0, 1);
    run_group(1, 2'd3, mk(1, 16, 512), 0, 0, 1);

    // All-zero group: result zero.
    for (int i = 0; i < GROUP; i++) begin g_act[i] = 16'h0000; g_wgt[i] = 4'($urandom_range(15, 0)); end
    run_group(1, 2'd3, mk(0, 15, 0), 0, 0, 1);

    // R2 and R1: metadata changes after beat 0 and idle gaps between beats.
    fill_random(10, 17);
    run_group(1, 2'd2, mk(0, 14, 300), 1, 1, 1);
    fill_random(10, 17);
    run_group(0, 2'd1, mk(1, 13, 40), 1, 1, 1);
    check(err == 1'b0, "R9 no error on finite inputs", longint'(err), 0);

    // R9: infinity sets a sticky flag.
    fill_random(10, 17);
    g_act[45] = 16'h7C00;
    run_group(1, 2'd0, mk(0, 15, 0), 0, 0, 0);
    check(err == 1'b1, "R9 err set by infinity", longint'(err), 1);
    fill_random(10, 17);
    run_group(1, 2'd1, mk(0, 15, 0), 0, 0, 1);
    check(err == 1'b1, "R9 err stays set", longint'(err), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule